// File: doc/BRIEF.md
# Programmable Signal Routing Fabric with Element Pool

This block is a small glue-logic fabric whose wiring is set entirely by register writes. A fixed pool of logic elements (two-input AND gates, two-input OR gates, one edge-triggered D flip-flop and one loadable down counter) sits beside a set of field input and field output pins. Every element input and every field output pin is a "slot". Each slot has its own selector register, and software sets the selector through a single write port.

A selector code picks one of four kinds of source:
- a constant low or high level;
- a one-clock software pulse;
- any internal signal, which may be a synchronized field input or an element output.

Bit 7 of every code inverts whatever was picked. Because of this, no element needs a complemented output.

Each slot registers the signal it selects, so the fabric contains no combinational loop whatever the routing. A typical use is to gate, count or re-time field signals by writing a short list of selector codes after reset.

Top module: `glue_route_fabric`

## Requirements
- R1: While reset is held and after it is released, every selector holds code 0 with inversion off, so `field_out` is 4'b0000.
- R2: Selector code 0 (bits 6:0) drives the slot low and code 1 drives it high. The new level shows in the clock cycle after the write.
- R3: Bit 7 of a selector code inverts the slot value. This applies to constants, pulses, routed signals and out-of-range codes alike.
- R4: Code 2 makes the slot high for exactly one cycle, the cycle after the write, and then low until the slot is written again. Writing code 2 again fires a new pulse.
- R5: Codes 3 and above select internal signal (code − 3). Signals 0–3 are field inputs 0–3, 4–5 are AND outputs 0–1, 6–7 are OR outputs 0–1, 8 is the flip-flop output and 9 is the counter zero flag. Codes 13 to 127 select a low level.
- R6: Slot addresses are as follows: 0–3 are the AND inputs (a0, b0, a1, b1), 4–7 are the OR inputs in the same order, 8 is flip-flop D, 9 is flip-flop clock, 10 is counter load, 11 is counter step, and 12–15 are field outputs 0–3. A write changes only the addressed slot.
- R7: Field inputs pass through two synchronizer flops. A field output routed straight from a field input follows it three clock edges after the input changes, and not earlier.
- R8: Each gate output is the AND or OR of its two slot values. Each slot adds one register, so a field input reaches a field output through one gate in four edges.
- R9: The flip-flop captures its D slot on a rising edge of its clock slot and holds at all other times. Its output resets to 0.
- R10: The counter resets to 0. A high load slot sets it to the preset (default 3). A rising edge on the step slot decrements it, and it stops at 0. The zero flag is high while the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Selector write strobe |
| wr_addr | input | 4 | Slot address of the write |
| wr_data | input | 8 | Selector code: bit 7 invert, bits 6:0 source |
| field_in | input | 4 | Asynchronous field input pins |
| field_out | output | 4 | Field output pins, one slot each |

## Verification
The bench sweeps every field input pattern through each field-to-field routing permutation, with inversion on alternate outputs. It checks both the sampling edge and the edge before it, so a synchronizer that is one flop short or one flop long is caught. Constants, pulses and out-of-range codes are swept on each output while the whole output vector is checked:
- a write that leaks into a neighbouring slot shows up on that neighbour;
- a pulse that lasts two cycles, or that never re-arms, fails the cycle-by-cycle pulse checks;
- a pulse that is not inverted fails them as well.

The gate sweep covers all sixteen input patterns through four gates, so a swapped gate type or a lost inversion shows up. The flip-flop and counter runs hunt for two faults:
- a flip-flop that captures without a clock edge;
- a counter that wraps below zero or ignores a reload.

// File: rtl/glue_pkg.sv
package glue_pkg;

    localparam int CODE_W        = 8;
    localparam int SEL_W         = 7;
    localparam int INV_BIT       = 7;
    localparam int CODE_LOW      = 0;
    localparam int CODE_HIGH     = 1;
    localparam int CODE_PULSE    = 2;
    localparam int CODE_SIG_BASE = 3;

    typedef enum logic [1:0] {
        SL_FOLLOW = 2'd0,
        SL_PULSE  = 2'd1,
        SL_REST   = 2'd2
    } slot_state_t;

    typedef enum logic {
        CNT_EMPTY = 1'b0,
        CNT_ARMED = 1'b1
    } cnt_state_t;

endpackage

// File: rtl/glue_sync.sv
module glue_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/glue_slot.sv
module glue_slot
    import glue_pkg::*;
#(
    parameter int NSIG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [NSIG-1:0]   sig,
    output logic              val
);

    slot_state_t      st_q, st_nx;
    logic [SEL_W-1:0] sel_q, sel_nx;
    logic             inv_q;
    logic             routed_q;
    logic             pick;
    logic             base;

    // selector that will be in force after this edge
    assign sel_nx = wr ? wr_code[SEL_W-1:0] : sel_q;

    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < NSIG; i++) begin
            if (int'(sel_nx) == CODE_SIG_BASE + i) pick = sig[i];
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st_q;
        if (wr) begin
            st_nx = (int'(wr_code[SEL_W-1:0]) == CODE_PULSE) ? SL_PULSE : SL_FOLLOW;
        end else begin
            unique case (st_q)
                SL_FOLLOW: st_nx = SL_FOLLOW;
                SL_PULSE:  st_nx = SL_REST;
                SL_REST:   st_nx = SL_REST;
                default:   st_nx = SL_FOLLOW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SL_FOLLOW;
        else        st_q <= st_nx;
    end

    // selector and routed-sample registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            inv_q    <= 1'b0;
            routed_q <= 1'b0;
        end else begin
            sel_q    <= sel_nx;
            routed_q <= pick;
            if (wr) inv_q <= wr_code[INV_BIT];
        end
    end

    // output logic
    always_comb begin
        unique case (st_q)
            SL_PULSE: base = 1'b1;
            SL_REST:  base = 1'b0;
            default: begin
                if (int'(sel_q) == CODE_LOW)       base = 1'b0;
                else if (int'(sel_q) == CODE_HIGH) base = 1'b1;
                else                               base = routed_q;
            end
        endcase
        val = base ^ inv_q;
    end

endmodule

// File: rtl/glue_pool.sv
module glue_pool
    import glue_pkg::*;
#(
    parameter int N_AND      = 2,
    parameter int N_OR       = 2,
    parameter int CNT_W      = 8,
    parameter int CNT_PRESET = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2*N_AND-1:0] and_in,
    input  logic [2*N_OR-1:0]  or_in,
    input  logic              ff_d,
    input  logic              ff_clk,
    input  logic              cnt_load,
    input  logic              cnt_step,
    output logic [N_AND-1:0]  and_y,
    output logic [N_OR-1:0]   or_y,
    output logic              ff_q,
    output logic              cnt_zero
);

    localparam logic [CNT_W-1:0] PRESET_V = CNT_W'(CNT_PRESET);
    localparam logic [CNT_W-1:0] ONE_V    = CNT_W'(1);

    for (genvar g = 0; g < N_AND; g++) begin : g_and
        assign and_y[g] = and_in[2*g] & and_in[2*g+1];
    end

    for (genvar g = 0; g < N_OR; g++) begin : g_or
        assign or_y[g] = or_in[2*g] | or_in[2*g+1];
    end

    // edge-triggered D flip-flop driven by a routed clock slot
    logic ff_clk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_clk_prev <= 1'b0;
            ff_q        <= 1'b0;
        end else begin
            ff_clk_prev <= ff_clk;
            if (ff_clk && !ff_clk_prev) ff_q <= ff_d;
        end
    end

    // loadable down counter
    cnt_state_t       cs_q, cs_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             step_prev;
    logic             step_rise;

    assign step_rise = cnt_step && !step_prev;

    always_comb begin
        cs_nx  = cs_q;
        cnt_nx = cnt_q;
        if (cnt_load) begin
            cnt_nx = PRESET_V;
            cs_nx  = (PRESET_V == '0) ? CNT_EMPTY : CNT_ARMED;
        end else if (step_rise) begin
            unique case (cs_q)
                CNT_ARMED: begin
                    cnt_nx = cnt_q - ONE_V;
                    if (cnt_q == ONE_V) cs_nx = CNT_EMPTY;
                end
                CNT_EMPTY: cnt_nx = cnt_q;
                default:   cs_nx  = CNT_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q      <= CNT_EMPTY;
            cnt_q     <= '0;
            step_prev <= 1'b0;
        end else begin
            cs_q      <= cs_nx;
            cnt_q     <= cnt_nx;
            step_prev <= cnt_step;
        end
    end

    always_comb begin
        cnt_zero = (cs_q == CNT_EMPTY);
    end

endmodule

// File: rtl/glue_route_fabric.sv
module glue_route_fabric
    import glue_pkg::*;
#(
    parameter int N_FIN      = 4,
    parameter int N_FOUT     = 4,
    parameter int N_AND      = 2,
    parameter int N_OR       = 2,
    parameter int CNT_W      = 8,
    parameter int CNT_PRESET = 3,
    localparam int AND_BASE  = 0,
    localparam int OR_BASE   = AND_BASE + 2*N_AND,
    localparam int FF_D      = OR_BASE + 2*N_OR,
    localparam int FF_CK     = FF_D + 1,
    localparam int CNT_LD    = FF_CK + 1,
    localparam int CNT_ST    = CNT_LD + 1,
    localparam int FOUT_BASE = CNT_ST + 1,
    localparam int N_SLOT    = FOUT_BASE + N_FOUT,
    localparam int ADDR_W    = $clog2(N_SLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [N_FIN-1:0]  field_in,
    output logic [N_FOUT-1:0] field_out
);

    localparam int N_SIG = N_FIN + N_AND + N_OR + 2;

    logic [N_FIN-1:0]  fin_s;
    logic [N_AND-1:0]  and_y;
    logic [N_OR-1:0]   or_y;
    logic              ff_q;
    logic              cnt_zero;
    logic [N_SIG-1:0]  sig;
    logic [N_SLOT-1:0] slot_val;

    glue_sync #(.W(N_FIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (field_in),
        .q     (fin_s)
    );

    assign sig = {cnt_zero, ff_q, or_y, and_y, fin_s};

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(s));
        glue_slot #(.NSIG(N_SIG)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (hit),
            .wr_code (wr_data),
            .sig     (sig),
            .val     (slot_val[s])
        );
    end

    glue_pool #(
        .N_AND      (N_AND),
        .N_OR       (N_OR),
        .CNT_W      (CNT_W),
        .CNT_PRESET (CNT_PRESET)
    ) u_pool (
        .clk      (clk),
        .rst_n    (rst_n),
        .and_in   (slot_val[AND_BASE +: 2*N_AND]),
        .or_in    (slot_val[OR_BASE +: 2*N_OR]),
        .ff_d     (slot_val[FF_D]),
        .ff_clk   (slot_val[FF_CK]),
        .cnt_load (slot_val[CNT_LD]),
        .cnt_step (slot_val[CNT_ST]),
        .and_y    (and_y),
        .or_y     (or_y),
        .ff_q     (ff_q),
        .cnt_zero (cnt_zero)
    );

    assign field_out = slot_val[FOUT_BASE +: N_FOUT];

endmodule

// File: rtl/glue_route_fabric_chk.sv
module glue_route_fabric_chk #(
    parameter int N_FOUT    = 4,
    parameter int FOUT_BASE = 12,
    parameter int AW        = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [7:0]        wr_data,
    input logic [N_FOUT-1:0] field_out
);

    for (genvar j = 0; j < N_FOUT; j++) begin : g_out
        localparam logic [AW-1:0] A = AW'(FOUT_BASE + j);

        // R4: pulse is high in the cycle after the write
        a_r4_pulse_high: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A && wr_data == 8'h02) |=> field_out[j]);

        // R4: pulse lasts a single cycle unless rewritten
        a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A && wr_data == 8'h02) ##1 !(wr_en && wr_addr == A)
            |=> !field_out[j]);

        // R2: constant high
        a_r2_const_high: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A && wr_data == 8'h01) |=> field_out[j]);

        // R2: constant low
        a_r2_const_low: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A && wr_data == 8'h00) |=> !field_out[j]);

        // R3: inverted constant high reads low
        a_r3_inverted_high: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A && wr_data == 8'h81) |=> !field_out[j]);
    end

endmodule

bind glue_route_fabric glue_route_fabric_chk #(
    .N_FOUT    (N_FOUT),
    .FOUT_BASE (FOUT_BASE),
    .AW        (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .field_out (field_out)
);

// File: tb/glue_route_fabric_test.sv
module glue_route_fabric_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] field_in;
    logic [3:0] field_out;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    glue_route_fabric uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .field_in  (field_in),
        .field_out (field_out)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: field_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int addr, input logic [7:0] code);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = code;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: field_out=%b expected=run end", field_out);
        finish_run();
    end

    initial begin
        logic [3:0] e;
        logic [3:0] prev;
        int cnt;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; field_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 in reset", field_out, 4'b0000);
        rst_n = 1'b1;
        field_in = 4'hF;
        repeat (4) @(negedge clk);
        chk("R1 after reset, inputs high", field_out, 4'b0000);
        field_in = 4'h0;
        repeat (3) @(negedge clk);

        // R2 / R3 / R6: constants and out-of-range codes per output
        e = 4'b0000;
        for (int j = 0; j < 4; j++) begin
            for (int c = 0; c < 7; c++) begin
                logic [7:0] code;
                case (c)
                    0: code = 8'h01; 1: code = 8'h00; 2: code = 8'h81;
                    3: code = 8'h80; 4: code = 8'h0D; 5: code = 8'h7F;
                    default: code = 8'h8D;
                endcase
                wr(12 + j, code);
                e[j] = (code[6:0] == 7'd1) ^ code[7];
                chk("R2/R3/R5/R6 const and range", field_out, e);
            end
        end

        // R4 / R3: pulses on each output
        for (int j = 0; j < 4; j++) wr(12 + j, 8'h00);
        for (int j = 0; j < 4; j++) begin
            wr(12 + j, 8'h02);
            chk("R4 pulse high", field_out, 4'(1 << j));
            @(negedge clk);
            chk("R4 pulse over", field_out, 4'b0000);
            @(negedge clk);
            chk("R4 stays low", field_out, 4'b0000);
            wr(12 + j, 8'h02);
            chk("R4 re-fire", field_out, 4'(1 << j));
            wr(12 + j, 8'h82);
            chk("R3 inverted pulse low", field_out, 4'b0000);
            @(negedge clk);
            chk("R3 inverted pulse rests high", field_out, 4'(1 << j));
            wr(12 + j, 8'h00);
        end

        // R7 / R5: direct field routing, every permutation and pattern
        for (int p = 0; p < 4; p++) begin
            for (int j = 0; j < 4; j++)
                wr(12 + j, ((j % 2) != 0 ? 8'h80 : 8'h00) | 8'(3 + (j + p) % 4));
            field_in = 4'h0;
            repeat (4) @(negedge clk);
            prev = 4'b0000;
            for (int v = 0; v < 16; v++) begin
                logic [3:0] vin;
                vin = 4'(v);
                field_in = vin;
                for (int j = 0; j < 4; j++) e[j] = vin[(j + p) % 4] ^ ((j % 2) != 0);
                repeat (2) @(negedge clk);
                if (v > 0) chk("R7 not before third edge", field_out, prev);
                @(negedge clk);
                chk("R7 routed field input", field_out, e);
                prev = e;
            end
        end

        // R8 / R6: gates between field pins
        wr(0, 8'h03); wr(1, 8'h04); wr(2, 8'h01); wr(3, 8'h05);
        wr(4, 8'h03); wr(5, 8'h84); wr(6, 8'h86); wr(7, 8'h00);
        wr(12, 8'h07); wr(13, 8'h09); wr(14, 8'h08); wr(15, 8'h0A);
        for (int v = 0; v < 16; v++) begin
            logic [3:0] vin;
            vin = 4'(v);
            field_in = vin;
            e[0] = vin[0] & vin[1];
            e[1] = vin[0] | ~vin[1];
            e[2] = vin[2];
            e[3] = ~vin[3];
            repeat (4) @(negedge clk);
            chk("R8 gate outputs", field_out, e);
        end

        // R9: flip-flop on field_out[0], D from field_in[0], clock by pulse
        for (int j = 0; j < 4; j++) wr(12 + j, 8'h00);
        wr(8, 8'h03);
        wr(12, 8'h0B);
        prev = 4'b0000;
        for (int k = 0; k < 6; k++) begin
            logic bitv;
            bitv = (k == 0 || k == 2 || k == 3);
            field_in = {3'b000, bitv};
            repeat (3) @(negedge clk);
            chk("R9 holds without clock edge", field_out, prev);
            wr(9, 8'h02);
            repeat (2) @(negedge clk);
            prev = {3'b000, bitv};
            chk("R9 captures on clock edge", field_out, prev);
        end

        // R10: counter zero flag on field_out[1]
        wr(12, 8'h00);
        wr(13, 8'h0C);
        chk("R10 reset count is zero", field_out, 4'b0010);
        wr(10, 8'h02);
        repeat (2) @(negedge clk);
        cnt = 3;
        chk("R10 load clears zero flag", field_out, 4'b0000);
        for (int s = 0; s < 5; s++) begin
            if (s == 1) begin
                wr(10, 8'h02);
                repeat (2) @(negedge clk);
                cnt = 3;
            end
            wr(11, 8'h02);
            repeat (2) @(negedge clk);
            if (cnt > 0) cnt--;
            chk("R10 step count", field_out, {2'b00, cnt == 0, 1'b0});
        end
        wr(11, 8'h02);
        repeat (2) @(negedge clk);
        chk("R10 no wrap below zero", field_out, 4'b0010);

        finish_run();
    end

endmodule